// File: doc/BRIEF.md
# Slow-Clock Register Write Synchronizer

This block holds the writable configuration registers of a peripheral whose logic runs on a slow clock, while software writes those registers from a fast bus clock. Each register has two copies. A staging copy lives in the fast domain and is loaded by the bus write. An applied copy lives in the slow domain and drives the peripheral. A write marks its register busy. The staged value then crosses to the slow domain through a toggle request and acknowledge handshake. The busy mark clears only once the acknowledge has been synchronized back into the fast domain.

A hold control lives in the fast domain. While it is set, staged writes collect and nothing crosses. When it is cleared, every collected register crosses in one batch, so the peripheral sees all of the new values on the same slow edge. A write aimed at a register that is still busy is discarded, and a sticky error flag records it.

Top module: `lfs_wsync`

## Requirements
- R1: After reset, every applied register reads RESET_VAL (default 0), and `busy_o`, `freeze_o` and `wr_err_o` are all 0.
- R2: A write to register k (`wr_addr` = k, with k < NUM_REGS) while `busy_o[k]` is 0 sets `busy_o[k]` at the next fast clock edge.
- R3: The applied copy of register k takes the written value on the third or fourth slow rising edge after the fast edge that took the write. It never changes earlier. Register k occupies bits [k*DATA_W +: DATA_W] of `active_o`.
- R4: `busy_o[k]` remains 1 until after the applied copy shows the new value, and then returns to 0 within a few fast cycles.
- R5: Writes to different registers are accepted independently. Writing register j while register k is busy stages j without error.
- R6: A write to a register whose busy flag is 1 is discarded. The value that finally reaches the applied copy is the earlier one.
- R7: A discarded write sets `wr_err_o`. Accepted writes never set it. Once set, it stays 1 until reset.
- R8: While the hold control is 1, no applied register changes, and staged registers keep their busy flags set.
- R9: When the hold control returns to 0, all registers that were staged while it was set change on the same slow clock edge.
- R10: The hold control sits at address NUM_REGS, in bit 0 of `wr_data`. It is stored in the fast domain and appears on `freeze_o` at the next fast edge, with no synchronization delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_clk | input | 1 | Fast bus clock |
| f_rst | input | 1 | Synchronous active-high reset, fast domain |
| wr_en | input | 1 | Write strobe, one fast cycle per write |
| wr_addr | input | ADDR_W (3) | Register index; NUM_REGS selects the hold control |
| wr_data | input | DATA_W (16) | Write data |
| s_clk | input | 1 | Slow peripheral clock |
| s_rst | input | 1 | Synchronous active-high reset, slow domain |
| active_o | output | NUM_REGS*DATA_W (64) | Applied register copies, register k at [k*DATA_W +: DATA_W] |
| busy_o | output | NUM_REGS (4) | Per-register transfer-in-progress flags |
| freeze_o | output | 1 | Current hold control value |
| wr_err_o | output | 1 | Sticky flag for discarded writes |

## Verification
Several internal faults show up at the ports. A lost or duplicated request toggle appears as an applied register that never updates, or one that updates off the three-to-four slow edge window. That window is measured in slow edges counted from the write. A busy flag that clears too early is caught in the very fast cycle where the new value first appears, because the flag must still be 1 there. A staging copy that takes a write while busy surfaces a few slow cycles later, as the wrong final value. Batching faults under the hold control are checked by sampling on every fast cycle after release, where any split between the two staged registers is visible.

// File: rtl/lfs_pkg.sv
`timescale 1ns/10ps
package lfs_pkg;
  // Flops per crossing synchronizer
  localparam int unsigned SYNC_DEPTH = 2;

  // Index width that can hold values 0..n-1 (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lfs_bit_sync.sv
`timescale 1ns/10ps
module lfs_bit_sync #(
  parameter int unsigned DEPTH = lfs_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], d};
  end

  assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/lfs_fast_ctrl.sv
`timescale 1ns/10ps
module lfs_fast_ctrl #(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                             f_clk,
  input  logic                             f_rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             ack_s,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  stage_o,
  output logic [NUM_REGS-1:0]              xfer_mask_o,
  output logic                             req_tgl_o,
  output logic [NUM_REGS-1:0]              busy_o,
  output logic                             freeze_o,
  output logic                             err_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] stage_q;
  logic [NUM_REGS-1:0] pend_q, mask_q, pend_nxt;
  logic [NUM_REGS-1:0] wr_sel, accept, launch_clr;
  logic inflight_q, req_q, ack_d, freeze_q, err_q;
  logic ack_evt, launch, freeze_hit, reject;

  // Per-register address decode
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  assign busy_o     = pend_q | mask_q;
  assign accept     = wr_sel & ~busy_o;
  assign reject     = |(wr_sel & busy_o);
  assign freeze_hit = wr_en && (wr_addr == ADDR_W'(NUM_REGS));
  assign ack_evt    = ack_s ^ ack_d;
  assign launch     = !inflight_q && !freeze_q && (|pend_q);
  assign launch_clr = launch ? pend_q : '0;
  assign pend_nxt   = (pend_q & ~launch_clr) | accept;

  always_ff @(posedge f_clk) begin
    if (f_rst) begin
      for (int i = 0; i < NUM_REGS; i++) stage_q[i] <= RESET_VAL;
      pend_q     <= '0;
      mask_q     <= '0;
      inflight_q <= 1'b0;
      req_q      <= 1'b0;
      ack_d      <= 1'b0;
      freeze_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      ack_d  <= ack_s;
      pend_q <= pend_nxt;
      for (int i = 0; i < NUM_REGS; i++)
        if (accept[i]) stage_q[i] <= wr_data;
      if (ack_evt) begin
        mask_q     <= '0;
        inflight_q <= 1'b0;
      end else if (launch) begin
        mask_q     <= pend_q;
        inflight_q <= 1'b1;
        req_q      <= ~req_q;
      end
      if (freeze_hit) freeze_q <= wr_data[0];
      if (reject)     err_q    <= 1'b1;
    end
  end

  assign stage_o     = stage_q;
  assign xfer_mask_o = mask_q;
  assign req_tgl_o   = req_q;
  assign freeze_o    = freeze_q;
  assign err_o       = err_q;

  // R7: the error flag never falls outside reset
  a_r7_err_sticky: assert property (@(posedge f_clk) disable iff (f_rst)
    err_q |=> err_q);

  // R8: no new crossing starts while the hold control is set
  a_r8_no_launch_frozen: assert property (@(posedge f_clk) disable iff (f_rst)
    freeze_q |=> $stable(req_q));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    // R2: an accepted write marks its register busy
    a_r2_busy_on_write: assert property (@(posedge f_clk) disable iff (f_rst)
      wr_sel[i] && !busy_o[i] |=> busy_o[i]);
    // R4: busy only clears on a returned acknowledge
    a_r4_busy_until_ack: assert property (@(posedge f_clk) disable iff (f_rst)
      busy_o[i] && !ack_evt |=> busy_o[i]);
    // R6: a busy register's staging copy is frozen
    a_r6_stage_stable: assert property (@(posedge f_clk) disable iff (f_rst)
      busy_o[i] |=> $stable(stage_q[i]));
  end
endmodule

// File: rtl/lfs_slow_apply.sv
`timescale 1ns/10ps
module lfs_slow_apply #(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                             s_clk,
  input  logic                             s_rst,
  input  logic                             req_s,
  input  logic [NUM_REGS-1:0]              xfer_mask_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  stage_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  active_o,
  output logic                             ack_tgl_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] active_q;
  logic req_d, arrive;

  assign arrive = req_s ^ req_d;

  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      for (int i = 0; i < NUM_REGS; i++) active_q[i] <= RESET_VAL;
      req_d <= 1'b0;
    end else begin
      req_d <= req_s;
      if (arrive)
        for (int i = 0; i < NUM_REGS; i++)
          if (xfer_mask_i[i]) active_q[i] <= stage_i[i];
    end
  end

  assign active_o  = active_q;
  assign ack_tgl_o = req_d;

  // R3: applied values move only when a request has arrived
  a_r3_apply_on_arrival: assert property (@(posedge s_clk) disable iff (s_rst)
    !arrive |=> $stable(active_q));
endmodule

// File: rtl/lfs_wsync.sv
`timescale 1ns/10ps
module lfs_wsync #(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int unsigned ADDR_W   = lfs_pkg::idx_width(NUM_REGS + 1)
) (
  input  logic                         f_clk,
  input  logic                         f_rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         s_clk,
  input  logic                         s_rst,
  output logic [NUM_REGS*DATA_W-1:0]   active_o,
  output logic [NUM_REGS-1:0]          busy_o,
  output logic                         freeze_o,
  output logic                         wr_err_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] stage, active;
  logic [NUM_REGS-1:0] xfer_mask;
  logic req_tgl, req_s, ack_tgl, ack_s;

  lfs_fast_ctrl #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL)
  ) u_fast (
    .f_clk(f_clk), .f_rst(f_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_s(ack_s), .stage_o(stage),
    .xfer_mask_o(xfer_mask), .req_tgl_o(req_tgl), .busy_o(busy_o),
    .freeze_o(freeze_o), .err_o(wr_err_o)
  );

  lfs_bit_sync u_req_sync (
    .clk(s_clk), .rst(s_rst), .d(req_tgl), .q(req_s)
  );

  lfs_slow_apply #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) u_slow (
    .s_clk(s_clk), .s_rst(s_rst), .req_s(req_s), .xfer_mask_i(xfer_mask),
    .stage_i(stage), .active_o(active), .ack_tgl_o(ack_tgl)
  );

  lfs_bit_sync u_ack_sync (
    .clk(f_clk), .rst(f_rst), .d(ack_tgl), .q(ack_s)
  );

  assign active_o = active;
endmodule

// File: tb/lfs_wsync_tb.sv
`timescale 1ns/10ps
module lfs_wsync_tb;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 3;

  logic f_clk = 0, s_clk = 0, f_rst = 1, s_rst = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N*DW-1:0] active_o;
  logic [N-1:0] busy_o;
  logic freeze_o, wr_err_o;

  int checks = 0, errors = 0, slow_cnt = 0, wr_cnt = 0;
  bit done = 0;

  lfs_wsync u_dut (
    .f_clk(f_clk), .f_rst(f_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .s_clk(s_clk), .s_rst(s_rst), .active_o(active_o),
    .busy_o(busy_o), .freeze_o(freeze_o), .wr_err_o(wr_err_o)
  );

  always #5 f_clk = ~f_clk;
  always #35.7 s_clk = ~s_clk;
  always @(posedge s_clk) slow_cnt <= slow_cnt + 1;

  function automatic logic [DW-1:0] act(input int i);
    return active_o[i*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(negedge f_clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = data;
    @(posedge f_clk);
    wr_cnt = slow_cnt;
    @(negedge f_clk);
    wr_en = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy_o != 0 && n < 400) begin
      @(negedge f_clk);
      n++;
    end
    chk(busy_o == 0, req, "busy clears", busy_o, 0);
  endtask

  task automatic t_reset;
    chk(active_o == 0, "R1", "applied after reset", active_o, 0);
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    chk(freeze_o == 0 && wr_err_o == 0, "R1", "hold/err after reset",
        {freeze_o, wr_err_o}, 0);
  endtask

  task automatic t_single;
    int n = 0; int edges; bit busy_at;
    wr(1, 16'hA5C3);
    chk(busy_o[1] == 1, "R2", "busy after write", busy_o[1], 1);
    chk(act(1) == 0, "R3", "no immediate update", act(1), 0);
    while (act(1) == 0 && n < 400) begin
      @(negedge f_clk);
      n++;
    end
    edges = slow_cnt - wr_cnt;
    busy_at = busy_o[1];
    chk(edges >= 3 && edges <= 4, "R3", "slow edges to update", edges, 3);
    chk(act(1) == 16'hA5C3, "R3", "applied value", act(1), 16'hA5C3);
    chk(busy_at == 1, "R4", "busy still set at update", busy_at, 1);
    wait_idle("R4");
    chk(act(1) == 16'hA5C3, "R4", "value kept after busy clears", act(1), 16'hA5C3);
  endtask

  task automatic t_two_regs;
    wr(2, 16'h1111);
    wr(3, 16'h2222);
    chk(busy_o[3:2] == 2'b11, "R5", "both staged", busy_o[3:2], 3);
    wait_idle("R5");
    chk(act(2) == 16'h1111, "R5", "reg2", act(2), 16'h1111);
    chk(act(3) == 16'h2222, "R5", "reg3", act(3), 16'h2222);
    chk(wr_err_o == 0, "R7", "no error on accepted writes", wr_err_o, 0);
  endtask

  task automatic t_drop;
    wr(0, 16'hBEEF);
    wr(0, 16'hDEAD);
    chk(wr_err_o == 1, "R7", "error on busy write", wr_err_o, 1);
    wait_idle("R6");
    chk(act(0) == 16'hBEEF, "R6", "dropped write ignored", act(0), 16'hBEEF);
    wr(0, 16'h1234);
    wait_idle("R6");
    chk(act(0) == 16'h1234, "R6", "later write accepted", act(0), 16'h1234);
    chk(wr_err_o == 1, "R7", "error sticky", wr_err_o, 1);
  endtask

  task automatic t_freeze;
    bit moved = 0; bit kept = 1; int n = 0; bit c1, c3;
    wr(N, 16'h0001);
    chk(freeze_o == 1, "R10", "hold set next edge", freeze_o, 1);
    wr(1, 16'h7777);
    wr(3, 16'h8888);
    repeat (100) begin
      @(negedge f_clk);
      if (act(1) != 16'hA5C3 || act(3) != 16'h2222) moved = 1;
      if (!(busy_o[1] && busy_o[3])) kept = 0;
    end
    chk(!moved, "R8", "no update while held", moved, 0);
    chk(kept, "R8", "busy held while frozen", kept, 1);
    wr(N, 16'h0000);
    chk(freeze_o == 0, "R10", "hold cleared next edge", freeze_o, 0);
    while (act(1) == 16'hA5C3 && act(3) == 16'h2222 && n < 400) begin
      @(negedge f_clk);
      n++;
    end
    c1 = (act(1) == 16'h7777);
    c3 = (act(3) == 16'h8888);
    chk(c1 && c3, "R9", "batch applied together", {c1, c3}, 3);
    wait_idle("R9");
    chk(act(1) == 16'h7777 && act(3) == 16'h8888, "R9", "final batch values",
        {act(1), act(3)}, {16'h7777, 16'h8888});
  endtask

  initial begin
    repeat (6) @(posedge s_clk);
    @(negedge f_clk);
    f_rst = 0; s_rst = 0;
    @(negedge f_clk);
    t_reset();
    t_single();
    t_two_regs();
    t_drop();
    t_freeze();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule